// File: doc/BRIEF.md
# Filter Drop Statistics and Capture Logger

This block keeps statistics on packets rejected by two rule filters, one for inbound and one for outbound traffic, each with 64 rules. Every rule of every filter owns an 8-bit drop counter. A drop event names the filter direction and the index of the matching rule, and the block increments that rule's counter. When a counter passes its maximum it wraps to zero and sets a sticky overflow flag. Any set flag raises the interrupt. Software may also poll the counters and flags through the read ports.

The block also copies the leading bytes of dropped packets into four capture slots of 60 bytes each. A capture starts only when the drop event falls on the first-byte beat of the packet stream. It then takes bytes until the end marker, keeps at most 60 of them, and records how many it kept. A mode input picks the policy that applies when slots run out. In overwrite mode the slots are reused in rotation. In hold mode stored packets are never replaced, and the interrupt is raised once every slot is occupied. The host frees a slot with a release pulse after reading it.

Top module: `drop_logger`

## Requirements
- R1: A drop event with direction d (0 inbound, 1 outbound) and rule index i increments only counter (d,i) by one; the read port shows the counter of the selected (direction, index) in the cycle after the update edge.
- R2: A drop on a counter holding 255 wraps it to 0 and sets that rule's sticky overflow flag; the interrupt is high while any overflow flag is set.
- R3: An overflow-clear pulse for (d,i) clears that flag only; the counter value is unchanged and the interrupt falls once no flag and no hold-full condition remains.
- R4: A capture stores the packet's byte k (k=0 is the start-of-packet byte) at slot position k for k<60; the recorded length of a longer packet is 60.
- R5: A packet shorter than 60 bytes records its true byte count as the slot length, and the slot reads as occupied after its end-of-packet byte.
- R6: In overwrite mode (hold_mode=0) successive captures use slots 0,1,2,3,0,... so that the fifth capture replaces the oldest one.
- R7: In hold mode (hold_mode=1) a capture uses the lowest-numbered free slot; a drop arriving while all slots are occupied still updates its counter but leaves every stored slot unchanged.
- R8: In hold mode the interrupt is high whenever all four slots are occupied.
- R9: A release pulse for slot s clears its occupied bit on the next edge, and a later hold-mode capture may reuse that slot.
- R10: After reset all counters read 0, no overflow flag is set, no slot is occupied and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_mode | input | 1 | 1 selects hold policy, 0 selects overwrite policy |
| drop_valid | input | 1 | Drop event strobe |
| drop_dir | input | 1 | Filter of the drop: 0 inbound, 1 outbound |
| drop_idx | input | 6 | Matching rule index |
| pkt_valid | input | 1 | Packet byte valid |
| pkt_sop | input | 1 | First byte of a packet |
| pkt_eop | input | 1 | Last byte of a packet |
| pkt_byte | input | 8 | Packet byte |
| cnt_rd_dir | input | 1 | Direction of counter to read |
| cnt_rd_idx | input | 6 | Rule index of counter to read |
| cnt_rd_value | output | 8 | Selected counter value |
| cnt_rd_ovf | output | 1 | Selected sticky overflow flag |
| ovf_clr | input | 1 | Clear pulse for one overflow flag |
| ovf_clr_dir | input | 1 | Direction of flag to clear |
| ovf_clr_idx | input | 6 | Rule index of flag to clear |
| cap_rd_slot | input | 2 | Capture slot to read |
| cap_rd_pos | input | 6 | Byte position to read (0..59) |
| cap_rd_byte | output | 8 | Captured byte at the selected position |
| cap_rd_len | output | 6 | Recorded length of the selected slot |
| slot_full | output | 4 | Occupied bit per capture slot |
| slot_rel | input | 1 | Release pulse |
| slot_rel_id | input | 2 | Slot to release |
| irq | output | 1 | Interrupt: any overflow flag, or hold mode with all slots occupied |

## Verification
The hardest case to reach is a counter overflow. It needs 256 drops aimed at one rule. The bench issues bare drop strobes with no packet stream, one per cycle, and checks the counter at 255 with no flag before it sends the drop that wraps. The hold-mode full state is reached with four short captures. A fifth captured drop then tests that the counter moves while the stored data and occupancy stay as they were. Releasing one slot and capturing again tests that the slot is reused and the interrupt falls.

// File: rtl/drop_logger.sv
module drop_logger #(
  parameter int ENTRIES   = 64,
  parameter int CNT_W     = 8,
  parameter int SLOTS     = 4,
  parameter int CAP_BYTES = 60,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int POS_W  = $clog2(CAP_BYTES),
  localparam int LEN_W  = $clog2(CAP_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_mode,
  input  logic              drop_valid,
  input  logic              drop_dir,
  input  logic [IDX_W-1:0]  drop_idx,
  input  logic              pkt_valid,
  input  logic              pkt_sop,
  input  logic              pkt_eop,
  input  logic [7:0]        pkt_byte,
  input  logic              cnt_rd_dir,
  input  logic [IDX_W-1:0]  cnt_rd_idx,
  output logic [CNT_W-1:0]  cnt_rd_value,
  output logic              cnt_rd_ovf,
  input  logic              ovf_clr,
  input  logic              ovf_clr_dir,
  input  logic [IDX_W-1:0]  ovf_clr_idx,
  input  logic [SLOT_W-1:0] cap_rd_slot,
  input  logic [POS_W-1:0]  cap_rd_pos,
  output logic [7:0]        cap_rd_byte,
  output logic [LEN_W-1:0]  cap_rd_len,
  output logic [SLOTS-1:0]  slot_full,
  input  logic              slot_rel,
  input  logic [SLOT_W-1:0] slot_rel_id,
  output logic              irq
);
  localparam int NCNT  = 2 * ENTRIES;
  localparam int CI_W  = $clog2(NCNT);
  localparam int MEM_N = SLOTS * CAP_BYTES;
  localparam int MEM_W = $clog2(MEM_N);

  logic [CNT_W-1:0] cnt_q [NCNT];
  logic [NCNT-1:0]  ovf_q;
  logic [7:0]       cap_mem [MEM_N];
  logic [LEN_W-1:0] len_q [SLOTS];
  logic [SLOTS-1:0] full_q;
  logic [SLOT_W-1:0] rr_q, cap_slot;
  logic [LEN_W-1:0] cap_pos;
  logic             cap_on;

  function automatic logic [CI_W-1:0] flat(input logic dir, input logic [IDX_W-1:0] idx);
    return dir ? CI_W'(ENTRIES) + CI_W'(idx) : CI_W'(idx);
  endfunction

  wire [CI_W-1:0] drop_ci = flat(drop_dir, drop_idx);
  wire [CI_W-1:0] clr_ci  = flat(ovf_clr_dir, ovf_clr_idx);
  wire [CI_W-1:0] rd_ci   = flat(cnt_rd_dir, cnt_rd_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCNT; k++) cnt_q[k] <= '0;
      ovf_q <= '0;
    end else begin
      if (ovf_clr) ovf_q[clr_ci] <= 1'b0;
      if (drop_valid) begin
        cnt_q[drop_ci] <= cnt_q[drop_ci] + 1'b1;
        if (&cnt_q[drop_ci]) ovf_q[drop_ci] <= 1'b1;
      end
    end
  end

  logic [SLOT_W-1:0] free_slot;
  logic              any_free;
  always_comb begin
    any_free  = 1'b0;
    free_slot = '0;
    for (int s = SLOTS - 1; s >= 0; s--)
      if (!full_q[s]) begin
        any_free  = 1'b1;
        free_slot = SLOT_W'(s);
      end
  end

  wire               start    = drop_valid & pkt_valid & pkt_sop & (~hold_mode | any_free);
  wire [SLOT_W-1:0]  tgt      = hold_mode ? free_slot : rr_q;
  wire               active   = pkt_valid & (start | (cap_on & ~pkt_sop));
  wire [SLOT_W-1:0]  cur_slot = start ? tgt : cap_slot;
  wire [LEN_W-1:0]   cur_pos  = start ? '0 : cap_pos;
  wire               room     = cur_pos < LEN_W'(CAP_BYTES);
  wire [LEN_W-1:0]   next_pos = room ? cur_pos + 1'b1 : cur_pos;
  wire [MEM_W-1:0]   wr_addr  = MEM_W'(cur_slot) * MEM_W'(CAP_BYTES) + MEM_W'(cur_pos);

  always_ff @(posedge clk)
    if (active && room) cap_mem[wr_addr] <= pkt_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q   <= '0;
      rr_q     <= '0;
      cap_slot <= '0;
      cap_pos  <= '0;
      cap_on   <= 1'b0;
      for (int s = 0; s < SLOTS; s++) len_q[s] <= '0;
    end else begin
      if (pkt_valid && pkt_sop && !start) cap_on <= 1'b0;
      if (start) begin
        full_q[tgt] <= 1'b0;
        cap_slot    <= tgt;
        if (!hold_mode) rr_q <= (rr_q == SLOT_W'(SLOTS - 1)) ? '0 : rr_q + 1'b1;
      end
      if (active) begin
        cap_pos <= next_pos;
        cap_on  <= ~pkt_eop;
        if (pkt_eop) begin
          full_q[cur_slot] <= 1'b1;
          len_q[cur_slot]  <= next_pos;
        end
      end
      if (slot_rel) full_q[slot_rel_id] <= 1'b0;
    end
  end

  wire [MEM_W-1:0] rd_addr = MEM_W'(cap_rd_slot) * MEM_W'(CAP_BYTES) + MEM_W'(cap_rd_pos);

  assign cnt_rd_value = cnt_q[rd_ci];
  assign cnt_rd_ovf   = ovf_q[rd_ci];
  assign cap_rd_byte  = (int'(cap_rd_pos) < CAP_BYTES) ? cap_mem[rd_addr] : 8'h00;
  assign cap_rd_len   = len_q[cap_rd_slot];
  assign slot_full    = full_q;
  assign irq          = (|ovf_q) | (hold_mode & (&full_q));
endmodule

// File: rtl/drop_logger_chk.sv
module drop_logger_chk #(
  parameter int SLOTS     = 4,
  parameter int SLOT_W    = 2,
  parameter int LEN_W     = 6,
  parameter int CAP_BYTES = 60,
  parameter int NCNT      = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_mode,
  input logic              irq,
  input logic [SLOTS-1:0]  full,
  input logic [NCNT-1:0]   ovf,
  input logic              slot_rel,
  input logic [SLOT_W-1:0] slot_rel_id,
  input logic [LEN_W-1:0]  cap_rd_len
);
  AST_OVF_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf) |-> irq); // R2

  AST_HOLD_FULL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && (&full)) |-> irq); // R8

  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rel |=> !full[$past(slot_rel_id)]); // R9

  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rd_len <= LEN_W'(CAP_BYTES)); // R4

  for (genvar s = 0; s < SLOTS; s++) begin : g_keep
    AST_HOLD_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_mode && full[s] && !(slot_rel && slot_rel_id == SLOT_W'(s))) |=> full[s]); // R7
  end
endmodule

bind drop_logger drop_logger_chk #(
  .SLOTS(SLOTS), .SLOT_W(SLOT_W), .LEN_W(LEN_W), .CAP_BYTES(CAP_BYTES), .NCNT(2 * ENTRIES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode), .irq(irq), .full(full_q), .ovf(ovf_q),
  .slot_rel(slot_rel), .slot_rel_id(slot_rel_id), .cap_rd_len(cap_rd_len)
);

// File: tb/drop_logger_tb.sv
`timescale 1ns/1ps
module drop_logger_tb;
  logic clk = 0, rst_n = 0, hold_mode = 0;
  logic drop_valid = 0, drop_dir = 0;
  logic [5:0] drop_idx = 0;
  logic pkt_valid = 0, pkt_sop = 0, pkt_eop = 0;
  logic [7:0] pkt_byte = 0;
  logic cnt_rd_dir = 0;
  logic [5:0] cnt_rd_idx = 0;
  logic [7:0] cnt_rd_value;
  logic cnt_rd_ovf;
  logic ovf_clr = 0, ovf_clr_dir = 0;
  logic [5:0] ovf_clr_idx = 0;
  logic [1:0] cap_rd_slot = 0;
  logic [5:0] cap_rd_pos = 0;
  logic [7:0] cap_rd_byte;
  logic [5:0] cap_rd_len;
  logic [3:0] slot_full;
  logic slot_rel = 0;
  logic [1:0] slot_rel_id = 0;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  drop_logger u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd_cnt(input logic d, input logic [5:0] i, output int v, output int o);
    cnt_rd_dir = d; cnt_rd_idx = i; #1;
    v = cnt_rd_value; o = cnt_rd_ovf;
  endtask

  task automatic rd_cap(input logic [1:0] s, input logic [5:0] p, output int b, output int l);
    cap_rd_slot = s; cap_rd_pos = p; #1;
    b = cap_rd_byte; l = cap_rd_len;
  endtask

  task automatic bare_drop(input logic d, input logic [5:0] i, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); drop_valid = 1; drop_dir = d; drop_idx = i;
    end
    @(negedge clk); drop_valid = 0;
  endtask

  task automatic send_pkt(input logic d, input logic [5:0] i, input int n, input logic [7:0] base);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      drop_valid = (k == 0); drop_dir = d; drop_idx = i;
      pkt_valid = 1; pkt_sop = (k == 0); pkt_eop = (k == n - 1);
      pkt_byte = base + 8'(k);
    end
    @(negedge clk); drop_valid = 0; pkt_valid = 0; pkt_sop = 0; pkt_eop = 0;
  endtask

  task automatic release_slot(input logic [1:0] s);
    @(negedge clk); slot_rel = 1; slot_rel_id = s;
    @(negedge clk); slot_rel = 0;
  endtask

  task automatic test_reset;
    int v, o;
    rd_cnt(1, 63, v, o);
    chk("R10 counter", v, 0); chk("R10 ovf", o, 0);
    chk("R10 slots", slot_full, 0); chk("R10 irq", irq, 0);
  endtask

  task automatic test_counts;
    int v, o;
    bare_drop(0, 3, 3);
    bare_drop(1, 3, 2);
    rd_cnt(0, 3, v, o); chk("R1 in[3]", v, 3);
    rd_cnt(1, 3, v, o); chk("R1 out[3]", v, 2);
    rd_cnt(0, 4, v, o); chk("R1 neighbour untouched", v, 0);
  endtask

  task automatic test_overflow;
    int v, o;
    bare_drop(1, 10, 255);
    rd_cnt(1, 10, v, o);
    chk("R2 at max", v, 255); chk("R2 no flag yet", o, 0); chk("R2 irq low", irq, 0);
    bare_drop(1, 10, 1);
    rd_cnt(1, 10, v, o);
    chk("R2 wrapped", v, 0); chk("R2 flag set", o, 1); chk("R2 irq high", irq, 1);
    @(negedge clk); ovf_clr = 1; ovf_clr_dir = 1; ovf_clr_idx = 10;
    @(negedge clk); ovf_clr = 0;
    rd_cnt(1, 10, v, o);
    chk("R3 flag cleared", o, 0); chk("R3 value kept", v, 0); chk("R3 irq low", irq, 0);
  endtask

  task automatic test_overwrite;
    int b, l, v, o;
    send_pkt(0, 20, 70, 8'h10);
    rd_cap(0, 0, b, l); chk("R4 byte0", b, 8'h10); chk("R4 len capped", l, 60);
    rd_cap(0, 59, b, l); chk("R4 byte59", b, 8'h4B);
    rd_cnt(0, 20, v, o); chk("R1 capture counted", v, 1);
    send_pkt(0, 21, 10, 8'h80);
    rd_cap(1, 9, b, l); chk("R5 byte9", b, 8'h89); chk("R5 short len", l, 10);
    chk("R5 occupied", slot_full, 4'b0011);
    send_pkt(0, 22, 4, 8'hC0);
    send_pkt(0, 23, 4, 8'hD0);
    rd_cap(3, 0, b, l); chk("R6 slot3", b, 8'hD0);
    send_pkt(0, 24, 5, 8'hA0);
    rd_cap(0, 0, b, l); chk("R6 oldest replaced", b, 8'hA0); chk("R6 new len", l, 5);
    rd_cap(1, 0, b, l); chk("R6 slot1 kept", b, 8'h80);
    chk("R6 irq low in overwrite", irq, 0);
  endtask

  task automatic test_hold;
    int b, l, v, o;
    for (int s = 0; s < 4; s++) release_slot(2'(s));
    chk("R9 all released", slot_full, 0);
    hold_mode = 1;
    for (int s = 0; s < 4; s++) send_pkt(1, 6'(40 + s), 8, 8'(s * 32));
    chk("R7 fills all", slot_full, 4'b1111);
    chk("R8 irq on full", irq, 1);
    rd_cap(3, 0, b, l); chk("R7 lowest free order", b, 8'h60);
    send_pkt(1, 30, 6, 8'hF0);
    rd_cnt(1, 30, v, o); chk("R7 counted while full", v, 1);
    rd_cap(0, 0, b, l); chk("R7 slot0 data kept", b, 8'h00); chk("R7 slot0 len kept", l, 8);
    chk("R7 occupancy kept", slot_full, 4'b1111);
    release_slot(2);
    chk("R9 slot2 freed", slot_full, 4'b1011);
    chk("R8 irq drops", irq, 0);
    send_pkt(1, 31, 3, 8'h33);
    rd_cap(2, 0, b, l); chk("R9 reused slot", b, 8'h33); chk("R9 reused len", l, 3);
    chk("R8 full again", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset;
    test_counts;
    test_overflow;
    test_overwrite;
    test_hold;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule